// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block moves a programmed number of words between one I/O device and system memory while sharing the system bus with a processor. The processor sets it up with a few register writes over a shared data bus. A select input picks the register. Two direction lines, given with the arming write, pick whether words go from memory to the device or from the device into memory. Once armed, the controller runs with no further help from the processor.

The controller never holds the bus for a burst. Each time the device shows it is ready, the controller asks for the bus. When the grant arrives it uses exactly one memory cycle to move one word. It then lets the bus go for at least one cycle before it can ask again, so the processor loses only one memory cycle per word. When the programmed count has been moved, it raises an interrupt that stays up until the processor clears it.

Top module: `cs_dma_ctrl`

## Requirements
- R1: A setup write (`cfg_wr` high while `busy` is low) with `cfg_sel` = 0 loads the device address (low DEV_W bits of `cfg_wdata`). `dev_addr` shows it from the next cycle. Select 1 loads the start memory address (low ADDR_W bits) and select 2 loads the word count (low CNT_W bits).
- R2: A write with `cfg_sel` = 3 and `cfg_wdata` bit 0 set arms the transfer only if exactly one direction line is high. `cfg_dir_rd` gives memory-to-device and `cfg_dir_wr` gives device-to-memory. With a non-zero count, `busy` rises the next cycle. If both lines or neither line is high, nothing starts.
- R3: `bus_req` is high only while busy. It rises one cycle after `dev_req` is sampled high in the waiting state.
- R4: When `bus_gnt` is sampled high with `bus_req`, `mem_cyc` and `dev_ack` are high in the next cycle for exactly one cycle, and one word moves in that cycle.
- R5: In the cycle after every `mem_cyc`, `bus_req` is low, which returns the bus to the processor.
- R6: Device-to-memory: during `mem_cyc`, `mem_we` = 1 and `mem_wdata` equals `dev_rdata`. Memory-to-device: `mem_we` = 0 and `dev_wdata` equals `mem_rdata`.
- R7: The first word uses the start address. Each later word uses the previous address plus one, wrapping modulo 2^ADDR_W.
- R8: After the programmed number of words, `busy` falls and `irq` rises in the cycle after the last `mem_cyc`, and no further bus request is made.
- R9: `irq` stays high until a control write with bit 1 set, or a valid arming write, clears it from the next cycle.
- R10: Arming with a count of zero raises `irq` in the next cycle without ever setting `busy` or `bus_req`.
- R11: While `busy` is high, every setup write is ignored, whatever the select. `busy` stays high from arming until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Setup write strobe |
| cfg_sel | input | 2 | Setup register select |
| cfg_wdata | input | DATA_W | Setup data lines |
| cfg_dir_rd | input | 1 | Direction line: memory to device |
| cfg_dir_wr | input | 1 | Direction line: device to memory |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_cyc | output | 1 | Stolen memory cycle in progress |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Word written to memory |
| mem_rdata | input | DATA_W | Word read from memory |
| dev_addr | output | DEV_W | Selected device address |
| dev_req | input | 1 | Device has a word ready or can accept one |
| dev_ack | output | 1 | Word taken from or given to the device |
| dev_wdata | output | DATA_W | Word to the device |
| dev_rdata | input | DATA_W | Word from the device |

## Verification
A wrong address pointer shows up on `mem_addr` in the very next stolen cycle, and a bad count shows up as an early or late `irq`. A control sequencer that stays in its transfer state shows up one cycle later as `bus_req` held across two words. The reference model follows the setup registers and the sequencing, and it compares every output on every clock. Any divergence is therefore reported in the cycle where it first reaches a port. Memory contents and the words delivered to the device are also compared after each transfer.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_REQ  = 2'd2,
      ST_XFER = 2'd3
   } dma_state_e;

   localparam logic [1:0] SEL_DEV  = 2'd0;
   localparam logic [1:0] SEL_ADDR = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_CLR_BIT = 1;

   typedef struct packed {
      logic go;
      logic clr;
      logic ld_addr;
      logic ld_cnt;
   } cfg_cmd_t;
endpackage

// File: rtl/cs_dma_cfg.sv
module cs_dma_cfg
   import cs_dma_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 12,
   parameter int DEV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_dir_rd,
   input  logic              cfg_dir_wr,
   input  logic              idle,
   output cfg_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr_val,
   output logic [CNT_W-1:0]  cnt_val,
   output logic [DEV_W-1:0]  dev_addr,
   output logic              to_mem
);
   logic wr_ok;
   logic dir_ok;
   logic [DEV_W-1:0] dev_val;

   generate
      if (DATA_W < ADDR_W) begin : g_chk_addr
         $error("cs_dma_cfg: DATA_W must cover ADDR_W");
      end
      if (DATA_W < CNT_W) begin : g_chk_cnt
         $error("cs_dma_cfg: DATA_W must cover CNT_W");
      end
      if (DATA_W < DEV_W) begin : g_chk_dev
         $error("cs_dma_cfg: DATA_W must cover DEV_W");
      end
      if (DATA_W < 2) begin : g_chk_ctrl
         $error("cs_dma_cfg: control bits need DATA_W >= 2");
      end
   endgenerate

   assign addr_val = cfg_wdata[ADDR_W-1:0];
   assign cnt_val  = cfg_wdata[CNT_W-1:0];
   assign dev_val  = cfg_wdata[DEV_W-1:0];

   assign wr_ok  = cfg_wr && idle;
   assign dir_ok = cfg_dir_rd ^ cfg_dir_wr;

   always_comb begin
      cmd.ld_addr = wr_ok && (cfg_sel == SEL_ADDR);
      cmd.ld_cnt  = wr_ok && (cfg_sel == SEL_CNT);
      cmd.go      = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT] && dir_ok;
      cmd.clr     = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_CLR_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_addr <= '0;
         to_mem   <= 1'b0;
      end else begin
         if (wr_ok && (cfg_sel == SEL_DEV)) begin
            dev_addr <= dev_val;
         end
         if (cmd.go) begin
            to_mem <= cfg_dir_wr;
         end
      end
   end
endmodule

// File: rtl/cs_dma_ptr.sv
module cs_dma_ptr #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [ADDR_W-1:0] addr_val,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              cnt_zero,
   output logic              cnt_last
);
   localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else begin
         if (ld_addr) begin
            addr <= addr_val;
         end else if (step) begin
            addr <= addr + ADDR_ONE;
         end
         if (ld_cnt) begin
            cnt <= cnt_val;
         end else if (step) begin
            cnt <= cnt - CNT_ONE;
         end
      end
   end

   assign cnt_zero = (cnt == '0);
   assign cnt_last = (cnt == CNT_ONE);
endmodule

// File: rtl/cs_dma_fsm.sv
module cs_dma_fsm
   import cs_dma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       clr,
   input  logic       cnt_zero,
   input  logic       cnt_last,
   input  logic       dev_req,
   input  logic       bus_gnt,
   output dma_state_e state,
   output logic       irq,
   output logic       step
);
   dma_state_e state_nx;
   logic       irq_set;

   assign step    = (state == ST_XFER);
   assign irq_set = (step && cnt_last) || (go && cnt_zero);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (go && !cnt_zero) state_nx = ST_WAIT;
         ST_WAIT: if (dev_req)         state_nx = ST_REQ;
         ST_REQ:  if (bus_gnt)         state_nx = ST_XFER;
         ST_XFER: state_nx = cnt_last ? ST_IDLE : ST_WAIT;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         irq   <= 1'b0;
      end else begin
         state <= state_nx;
         if (irq_set) begin
            irq <= 1'b1;
         end else if (go || clr) begin
            irq <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
   import cs_dma_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 12,
   parameter int DEV_W     = 8,
   parameter bit QUIET_BUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              cfg_dir_rd,
   input  logic              cfg_dir_wr,
   output logic              busy,
   output logic              irq,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_cyc,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DEV_W-1:0]  dev_addr,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic [DATA_W-1:0] dev_rdata
);
   cfg_cmd_t          cmd;
   logic [ADDR_W-1:0] addr_val;
   logic [CNT_W-1:0]  cnt_val;
   logic [ADDR_W-1:0] ptr_addr;
   logic              to_mem;
   logic              cnt_zero;
   logic              cnt_last;
   logic              step;
   dma_state_e        state;

   generate
      if (CNT_W < 1 || ADDR_W < 1 || DEV_W < 1) begin : g_chk_w
         $error("cs_dma_ctrl: widths must be positive");
      end
   endgenerate

   cs_dma_cfg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_dir_rd(cfg_dir_rd), .cfg_dir_wr(cfg_dir_wr),
      .idle(!busy), .cmd(cmd), .addr_val(addr_val), .cnt_val(cnt_val),
      .dev_addr(dev_addr), .to_mem(to_mem)
   );

   cs_dma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld_addr(cmd.ld_addr), .ld_cnt(cmd.ld_cnt),
      .addr_val(addr_val), .cnt_val(cnt_val), .step(step),
      .addr(ptr_addr), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
   );

   cs_dma_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .go(cmd.go), .clr(cmd.clr),
      .cnt_zero(cnt_zero), .cnt_last(cnt_last), .dev_req(dev_req),
      .bus_gnt(bus_gnt), .state(state), .irq(irq), .step(step)
   );

   assign busy    = (state != ST_IDLE);
   assign bus_req = (state == ST_REQ) || (state == ST_XFER);
   assign mem_cyc = step;
   assign dev_ack = step;
   assign mem_we  = step && to_mem;

   generate
      if (QUIET_BUS) begin : g_quiet
         assign mem_addr  = step ? ptr_addr : '0;
         assign mem_wdata = (step && to_mem) ? dev_rdata : '0;
         assign dev_wdata = (step && !to_mem) ? mem_rdata : '0;
      end else begin : g_open
         assign mem_addr  = ptr_addr;
         assign mem_wdata = dev_rdata;
         assign dev_wdata = mem_rdata;
      end
   endgenerate
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [1:0]        cfg_sel,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              cfg_dir_rd,
   input logic              cfg_dir_wr,
   input logic              busy,
   input logic              irq,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              mem_cyc,
   input logic              dev_req
);
   AST_CYC_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cyc |-> $past(bus_req && bus_gnt)); // R4
   AST_CYC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cyc |=> !mem_cyc); // R4
   AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cyc |=> !bus_req); // R5
   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy); // R3
   AST_REQ_AFTER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(dev_req)); // R3
   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy); // R8
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(cfg_wr && cfg_sel == 2'd3 && (cfg_wdata[0] || cfg_wdata[1]))) |=> irq); // R9
   AST_BUSY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_wr && cfg_sel == 2'd3 && cfg_wdata[0] && (cfg_dir_rd != cfg_dir_wr))); // R2
endmodule

bind cs_dma_ctrl cs_dma_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
   .cfg_wdata(cfg_wdata), .cfg_dir_rd(cfg_dir_rd), .cfg_dir_wr(cfg_dir_wr),
   .busy(busy), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .mem_cyc(mem_cyc), .dev_req(dev_req)
);

// File: tb/cs_dma_ctrl_tb.sv
module cs_dma_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        cfg_dir_rd = 1'b0;
   logic        cfg_dir_wr = 1'b0;
   logic        busy, irq, bus_req, mem_cyc, mem_we, dev_ack;
   logic        bus_gnt = 1'b0;
   logic        dev_req = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
   logic [7:0]  dev_addr;

   int checks = 0;
   int errors = 0;
   int cyc_n = 0;
   bit dev_en = 1'b0;
   bit last_cyc = 1'b0;
   logic [15:0] tb_mem [0:255];
   int src_n = 0;

   // reference model state
   int          m_state;
   logic [7:0]  m_dev;
   logic [15:0] m_addr;
   logic [11:0] m_cnt;
   logic        m_dir;
   logic        m_irq;

   always #10 clk = ~clk;

   cs_dma_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_dir_rd(cfg_dir_rd), .cfg_dir_wr(cfg_dir_wr),
      .busy(busy), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .mem_cyc(mem_cyc), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
      .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata)
   );

   assign mem_rdata = tb_mem[mem_addr[7:0]];
   assign dev_rdata = 16'hA000 + src_n[15:0];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc_n);
      end
   endtask

   // memory and device source
   always @(posedge clk) begin
      if (mem_cyc && mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;
      if (dev_ack) src_n <= src_n + 1;
   end

   // reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_dev = 0; m_addr = 0; m_cnt = 0; m_dir = 0; m_irq = 0;
      end else begin
         case (m_state)
            0: if (cfg_wr) begin
               case (cfg_sel)
                  2'd0: m_dev = cfg_wdata[7:0];
                  2'd1: m_addr = cfg_wdata;
                  2'd2: m_cnt = cfg_wdata[11:0];
                  default: begin
                     if (cfg_wdata[0] && (cfg_dir_rd != cfg_dir_wr)) begin
                        m_dir = cfg_dir_wr;
                        if (m_cnt == 0) m_irq = 1'b1;
                        else begin m_irq = 1'b0; m_state = 1; end
                     end else if (cfg_wdata[1]) m_irq = 1'b0;
                  end
               endcase
            end
            1: if (dev_req) m_state = 2;
            2: if (bus_gnt) m_state = 3;
            default: begin
               m_addr = m_addr + 16'd1;
               m_cnt  = m_cnt - 12'd1;
               if (m_cnt == 0) begin m_irq = 1'b1; m_state = 0; end
               else m_state = 1;
            end
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R11 busy", busy, m_state != 0);
         chk("R3 bus_req", bus_req, (m_state == 2) || (m_state == 3));
         chk("R4 mem_cyc", mem_cyc, m_state == 3);
         chk("R4 dev_ack", dev_ack, m_state == 3);
         chk("R8 irq", irq, m_irq);
         chk("R1 dev_addr", dev_addr, m_dev);
         if (last_cyc) chk("R5 release", bus_req, 1'b0);
         if (m_state == 3) begin
            chk("R7 mem_addr", mem_addr, m_addr);
            chk("R6 mem_we", mem_we, m_dir);
            if (m_dir) chk("R6 mem_wdata", mem_wdata, 16'hA000 + src_n[15:0]);
            else chk("R6 dev_wdata", dev_wdata, tb_mem[m_addr[7:0]]);
         end else begin
            chk("R6 mem_we idle", mem_we, 1'b0);
         end
         last_cyc = mem_cyc;
      end
   end

   // device and bus arbiter behaviour
   always @(negedge clk) begin
      #2;
      dev_req <= dev_en && ($urandom_range(0, 3) != 0);
      bus_gnt <= bus_req && ($urandom_range(0, 2) != 0);
   end

   // watchdog
   always @(posedge clk) begin
      cyc_n++;
      if (cyc_n > 50000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic cfg_write(input logic [1:0] sel, input logic [15:0] data,
                            input logic rd, input logic wr);
      @(negedge clk); #2;
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data; cfg_dir_rd = rd; cfg_dir_wr = wr;
      @(negedge clk); #2;
      cfg_wr = 1'b0; cfg_dir_rd = 1'b0; cfg_dir_wr = 1'b0; cfg_wdata = 16'd0;
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
      @(negedge clk);
   endtask

   int base_n;

   initial begin
      for (int i = 0; i < 256; i++) tb_mem[i] = 16'h0100 + 16'(i * 3);
      repeat (4) @(negedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R11 reset busy", busy, 1'b0);
      chk("R8 reset irq", irq, 1'b0);
      chk("R3 reset bus_req", bus_req, 1'b0);

      // device to memory, 4 words at 0x0010
      dev_en = 1'b1;
      cfg_write(2'd0, 16'h005A, 0, 0);
      cfg_write(2'd1, 16'h0010, 0, 0);
      cfg_write(2'd2, 16'd4, 0, 0);
      base_n = src_n;
      cfg_write(2'd3, 16'h0001, 0, 1);
      chk("R2 busy after arm", busy, 1'b1);
      wait_irq();
      for (int i = 0; i < 4; i++)
         chk("R6 stored word", tb_mem[16 + i], 16'hA000 + 16'(base_n + i));
      chk("R8 busy low at end", busy, 1'b0);
      chk("R1 dev_addr value", dev_addr, 8'h5A);

      // clear interrupt
      cfg_write(2'd3, 16'h0002, 0, 0);
      chk("R9 irq cleared", irq, 1'b0);

      // memory to device, 3 words
      cfg_write(2'd1, 16'h0020, 0, 0);
      cfg_write(2'd2, 16'd3, 0, 0);
      cfg_write(2'd3, 16'h0001, 1, 0);
      wait_irq();
      chk("R8 irq after read run", irq, 1'b1);

      // irq held through unrelated writes, cleared by a new arm
      cfg_write(2'd0, 16'h0011, 0, 0);
      chk("R9 irq held", irq, 1'b1);
      cfg_write(2'd2, 16'd2, 0, 0);
      cfg_write(2'd3, 16'h0001, 1, 0);
      chk("R9 irq cleared by arm", irq, 1'b0);
      wait_irq();

      // zero count
      cfg_write(2'd3, 16'h0002, 0, 0);
      cfg_write(2'd2, 16'd0, 0, 0);
      cfg_write(2'd3, 16'h0001, 0, 1);
      chk("R10 irq at once", irq, 1'b1);
      chk("R10 not busy", busy, 1'b0);
      repeat (5) @(negedge clk);
      chk("R10 no bus request", bus_req, 1'b0);

      // invalid direction lines
      cfg_write(2'd3, 16'h0002, 0, 0);
      cfg_write(2'd2, 16'd3, 0, 0);
      cfg_write(2'd3, 16'h0001, 1, 1);
      chk("R2 both lines ignored", busy, 1'b0);
      cfg_write(2'd3, 16'h0001, 0, 0);
      chk("R2 no line ignored", busy, 1'b0);
      chk("R2 irq still clear", irq, 1'b0);

      // writes while busy are ignored
      dev_en = 1'b0;
      cfg_write(2'd1, 16'h0040, 0, 0);
      cfg_write(2'd2, 16'd2, 0, 0);
      base_n = src_n;
      cfg_write(2'd3, 16'h0001, 0, 1);
      cfg_write(2'd1, 16'h0080, 0, 0);
      cfg_write(2'd2, 16'd5, 0, 0);
      cfg_write(2'd0, 16'h0033, 0, 0);
      cfg_write(2'd3, 16'h0001, 1, 0);
      chk("R11 dev_addr kept", dev_addr, 8'h11);
      chk("R11 still busy", busy, 1'b1);
      dev_en = 1'b1;
      wait_irq();
      chk("R11 word 0 at old addr", tb_mem[8'h40], 16'hA000 + 16'(base_n));
      chk("R11 word 1 at old addr", tb_mem[8'h41], 16'hA000 + 16'(base_n + 1));
      chk("R11 new addr untouched", tb_mem[8'h80], 16'h0100 + 16'(8'h80 * 3));

      // address wrap
      cfg_write(2'd1, 16'hFFFE, 0, 0);
      cfg_write(2'd2, 16'd3, 0, 0);
      base_n = src_n;
      cfg_write(2'd3, 16'h0003, 0, 1);
      wait_irq();
      chk("R7 wrap word 0", tb_mem[8'hFE], 16'hA000 + 16'(base_n));
      chk("R7 wrap word 2", tb_mem[8'h00], 16'hA000 + 16'(base_n + 2));

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule